// File: doc/BRIEF.md
# Program Counter Sequencer with Branch, Jump and Link

This block keeps the program counter of a 32-bit load/store processor and decides, once per clock, which address the core fetches next. The decode stage hands it a small control-flow code, the 16-bit branch displacement and the 26-bit jump field from the instruction word, and the two register values read for that instruction. From these the block forms the fall-through address, a PC-relative branch target, a region-local absolute jump target, or a register-indirect target. It picks one of them and loads it into the PC on the next clock edge.

For call instructions the block also presents the return address on a link-value output. It raises a write strobe and gives the index of the return-address register, so the register file can store the link in the same cycle the jump is taken. A step-enable input lets the surrounding pipeline freeze the PC during stalls. A synchronous active-low reset loads a parameterized start address.

Top module: `pc_step_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc_q` is loaded with the parameter `RESET_VEC` (default 0). Reset takes effect only at a clock edge, never between edges.
- R2: With step enabled and `flow_kind` equal to 0 (sequential), or to either unused code 6 or 7, the next PC is `pc_q + 4`.
- R3: With `flow_kind` equal to 1 (branch-if-equal), the next PC is `pc_q + 4 + (offset << 2)` when `opnd_a == opnd_b`, and `pc_q + 4` otherwise.
- R4: With `flow_kind` equal to 2 (branch-if-different), the next PC is `pc_q + 4 + (offset << 2)` when `opnd_a != opnd_b`, and `pc_q + 4` otherwise.
- R5: `br_offset` is treated as a two's-complement value and sign-extended before scaling, so offsets 0x8000 to 0xFFFF move the PC backwards.
- R6: With `flow_kind` equal to 3 (jump), the next PC is `{(pc_q+4)[31:28], jmp_field, 2'b00}`. The top nibble comes from the incremented PC, which matters when the PC is in the last word of a 256 MB region.
- R7: With `flow_kind` equal to 4 (jump-and-link), the next PC is formed as in R6. In that same cycle `link_we` is 1, `link_value` equals `pc_q + 4`, and `link_reg` equals 31.
- R8: With `flow_kind` equal to 5 (register-indirect jump), the next PC equals `opnd_a` exactly.
- R9: While `step_en` is 0, `pc_q` keeps its value at the clock edge and `link_we` is 0, whatever the flow code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance the PC this cycle when high |
| flow_kind | input | 3 | Control-flow code: 0 seq, 1 beq, 2 bne, 3 jump, 4 jump-and-link, 5 register jump, 6/7 seq |
| br_offset | input | 16 | Signed word displacement for branches |
| jmp_field | input | 26 | Word index for region-local jumps |
| opnd_a | input | 32 | First compare operand; target address for register jumps |
| opnd_b | input | 32 | Second compare operand |
| pc_q | output | 32 | Current program counter |
| link_value | output | 32 | Return address (`pc_q + 4`) |
| link_we | output | 1 | Write strobe for the return-address register |
| link_reg | output | 5 | Index of the return-address register (31) |

## Verification
The embedded properties assume that `rst_n` is driven low before the first edge and that every input is a known value at each sampling edge. Beyond that, any flow code, offset, jump field and operand pair is legal. The properties therefore cover unaligned register-jump targets and region-boundary jumps without extra guards. The stimulus changes inputs only on the falling clock edge and holds reset low for several cycles at start-up. It deliberately lands the PC on the last word of a 256 MB region before a jump, and it uses the extreme positive and negative displacements.

// File: rtl/pcu_pkg.sv
// Package: shared control-flow encoding and widths for the PC sequencer.
// Assumes the decode stage produces the 3-bit code defined here.
package pcu_pkg;
    localparam int unsigned FLOW_W = 3;

    typedef enum logic [FLOW_W-1:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_JAL  = 3'd4,
        FLOW_JREG = 3'd5,
        FLOW_RSV6 = 3'd6,
        FLOW_RSV7 = 3'd7
    } flow_e;
endpackage

// File: rtl/pcu_seq_adder.sv
// Module: fall-through address generator.
// Adds the fixed instruction size to the current PC; wraps modulo 2^XLEN.
module pcu_seq_adder #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_cur,
    output logic [XLEN-1:0] pc_inc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    // Purpose: form the address of the following instruction.
    always_comb begin
        pc_inc = pc_cur + STEP;
    end
endmodule

// File: rtl/pcu_target_calc.sv
// Module: candidate target builder.
// Produces the PC-relative branch target (sign-extended, word scaled) and
// the region-local jump target (upper bits of the incremented PC spliced
// over the jump field). Assumes word-aligned instructions of 4 bytes.
module pcu_target_calc #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned JT_W  = 26
) (
    input  logic [XLEN-1:0]  pc_inc,
    input  logic [OFF_W-1:0] br_offset,
    input  logic [JT_W-1:0]  jmp_field,
    output logic [XLEN-1:0]  br_target,
    output logic [XLEN-1:0]  jmp_target
);
    localparam int unsigned ALIGN_W  = 2;
    localparam int unsigned EXT_W    = XLEN - OFF_W - ALIGN_W;
    localparam int unsigned REGION_W = XLEN - JT_W - ALIGN_W;

    logic [XLEN-1:0] disp;

    // Purpose: sign-extend the displacement and scale it to bytes.
    always_comb begin
        disp = {{EXT_W{br_offset[OFF_W-1]}}, br_offset, {ALIGN_W{1'b0}}};
    end

    // Purpose: add the scaled displacement to the fall-through address.
    always_comb begin
        br_target = pc_inc + disp;
    end

    // Purpose: keep the region bits of the incremented PC, replace the rest.
    always_comb begin
        jmp_target = {pc_inc[XLEN-1 -: REGION_W], jmp_field, {ALIGN_W{1'b0}}};
    end
endmodule

// File: rtl/pcu_flow_select.sv
// Module: next-address chooser.
// Resolves branch conditions from the two operands and selects the next PC
// among the candidates; flags call instructions. Unused codes fall through.
module pcu_flow_select
    import pcu_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [FLOW_W-1:0] flow_kind,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [XLEN-1:0]   pc_inc,
    input  logic [XLEN-1:0]   br_target,
    input  logic [XLEN-1:0]   jmp_target,
    output logic [XLEN-1:0]   pc_next,
    output logic              is_call
);
    flow_e flow;
    logic  ops_equal;

    // Purpose: decode the flow code and compare the operands.
    always_comb begin
        flow      = flow_e'(flow_kind);
        ops_equal = (opnd_a == opnd_b);
    end

    // Purpose: pick the next address for the decoded flow.
    always_comb begin
        is_call = 1'b0;
        case (flow)
            FLOW_BEQ:  pc_next = ops_equal ? br_target : pc_inc;
            FLOW_BNE:  pc_next = ops_equal ? pc_inc : br_target;
            FLOW_JMP:  pc_next = jmp_target;
            FLOW_JAL: begin
                pc_next = jmp_target;
                is_call = 1'b1;
            end
            FLOW_JREG: pc_next = opnd_a;
            default:   pc_next = pc_inc;
        endcase
    end
endmodule

// File: rtl/pc_step_unit.sv
// Module: program counter register with branch, jump and link support.
// Holds the PC, advances it on step_en, and presents the return address
// with a write strobe for call instructions. Synchronous active-low reset.
// Assumes inputs are stable and known around each rising clock edge.
module pc_step_unit
    import pcu_pkg::*;
#(
    parameter int unsigned     XLEN      = 32,
    parameter int unsigned     OFF_W     = 16,
    parameter int unsigned     JT_W      = 26,
    parameter int unsigned     REG_IDX_W = 5,
    parameter int unsigned     LINK_IDX  = 31,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic [FLOW_W-1:0]    flow_kind,
    input  logic [OFF_W-1:0]     br_offset,
    input  logic [JT_W-1:0]      jmp_field,
    input  logic [XLEN-1:0]      opnd_a,
    input  logic [XLEN-1:0]      opnd_b,
    output logic [XLEN-1:0]      pc_q,
    output logic [XLEN-1:0]      link_value,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_reg
);
    localparam int unsigned REGION_W = XLEN - JT_W - 2;

    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic [XLEN-1:0] pc_next;
    logic            is_call;

    pcu_seq_adder #(.XLEN(XLEN), .INSN_BYTES(4)) u_inc (
        .pc_cur (pc_q),
        .pc_inc (pc_inc)
    );

    pcu_target_calc #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W)) u_tgt (
        .pc_inc     (pc_inc),
        .br_offset  (br_offset),
        .jmp_field  (jmp_field),
        .br_target  (br_target),
        .jmp_target (jmp_target)
    );

    pcu_flow_select #(.XLEN(XLEN)) u_sel (
        .flow_kind  (flow_kind),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .pc_inc     (pc_inc),
        .br_target  (br_target),
        .jmp_target (jmp_target),
        .pc_next    (pc_next),
        .is_call    (is_call)
    );

    // Purpose: the PC register; reset vector, advance on step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_VEC;
        end else if (step_en) begin
            pc_q <= pc_next;
        end
    end

    // Purpose: drive the return-address write to the register file.
    always_comb begin
        link_value = pc_inc;
        link_we    = step_en && is_call;
        link_reg   = REG_IDX_W'(LINK_IDX);
    end

    // R1: a reset edge leaves the start address in the PC.
    assert_reset_vec_R1: assert property (@(posedge clk)
        !rst_n |=> pc_q == RESET_VEC)
        else $error("R1 reset vector not loaded");

    // R2: a sequential step advances by one instruction.
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && flow_kind == FLOW_SEQ) |=> pc_q == $past(pc_q) + XLEN'(4))
        else $error("R2 sequential step wrong");

    // R7: a call keeps the region of the returned link address.
    assert_call_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |=> pc_q[XLEN-1 -: REGION_W] == $past(link_value[XLEN-1 -: REGION_W]))
        else $error("R7 call left its region");

    // R8: a register jump lands exactly on the operand.
    assert_reg_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && flow_kind == FLOW_JREG) |=> pc_q == $past(opnd_a))
        else $error("R8 register jump wrong");

    // R9: with stepping off the PC holds.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pc_q))
        else $error("R9 PC moved while frozen");
endmodule

// File: tb/sim_pc_step_unit.sv
module sim_pc_step_unit;
    localparam logic [31:0] RV = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [2:0]  flow_kind = 3'd0;
    logic [15:0] br_offset = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] pc_q, link_value;
    logic        link_we;
    logic [4:0]  link_reg;

    int total = 0;
    int bad = 0;
    logic [31:0] model_pc;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    pc_step_unit #(.RESET_VEC(RV)) u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .flow_kind(flow_kind),
        .br_offset(br_offset), .jmp_field(jmp_field), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .pc_q(pc_q), .link_value(link_value),
        .link_we(link_we), .link_reg(link_reg)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference next-address model written from the requirements.
    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [2:0] fk,
                                              input logic [15:0] off, input logic [25:0] jf,
                                              input logic [31:0] a, input logic [31:0] b);
        logic [31:0] inc, btg;
        inc = pc + 32'd4;
        btg = inc + (32'(signed'(off)) <<< 2);
        case (fk)
            3'd1: return (a == b) ? btg : inc;
            3'd2: return (a != b) ? btg : inc;
            3'd3, 3'd4: return {inc[31:28], jf, 2'b00};
            3'd5: return a;
            default: return inc;
        endcase
    endfunction

    // Driver: apply one step at the falling edge, check link outputs, queue expected PC.
    task automatic drive(input string req, input bit en, input logic [2:0] fk,
                         input logic [15:0] off, input logic [25:0] jf,
                         input logic [31:0] a, input logic [31:0] b);
        logic [31:0] nxt;
        @(negedge clk);
        step_en = en; flow_kind = fk; br_offset = off; jmp_field = jf; opnd_a = a; opnd_b = b;
        #1;
        if (en && fk == 3'd4) begin
            check(link_we === 1'b1, "R7 link_we", {31'd0, link_we}, 32'd1);
            check(link_value === model_pc + 32'd4, "R7 link_value", link_value, model_pc + 32'd4);
            check(link_reg === 5'd31, "R7 link_reg", {27'd0, link_reg}, 32'd31);
        end else if (!en) begin
            check(link_we === 1'b0, "R9 link_we low while frozen", {31'd0, link_we}, 32'd0);
        end
        nxt = en ? ref_next(model_pc, fk, off, jf, a, b) : model_pc;
        model_pc = nxt;
        exp_q.push_back(nxt);
        tag_q.push_back(req);
        @(posedge clk);
    endtask

    // Monitor: after each edge compare the PC with the oldest expectation.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(pc_q === e, t, pc_q, e);
        end
    end

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", pc_q, model_pc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        repeat (3) @(posedge clk);
        #2;
        check(pc_q === RV, "R1 reset value", pc_q, RV);
        check(link_we === 1'b0, "R9 link_we idle", {31'd0, link_we}, 32'd0);
        model_pc = RV;
        @(negedge clk);
        rst_n = 1'b1;

        drive("R2 sequential",          1, 3'd0, 16'd5,    26'd0, 32'd0, 32'd0);
        drive("R3 beq taken",           1, 3'd1, 16'd3,    26'd0, 32'd7, 32'd7);
        drive("R3 beq not taken",       1, 3'd1, 16'd3,    26'd0, 32'd7, 32'd8);
        drive("R4 R5 bne taken back",   1, 3'd2, 16'hFFFE, 26'd0, 32'd1, 32'd2);
        drive("R4 bne not taken",       1, 3'd2, 16'h0040, 26'd0, 32'd9, 32'd9);
        drive("R9 hold on jal",         0, 3'd4, 16'd0,    26'h0000100, 32'd0, 32'd0);
        drive("R7 jal target",          1, 3'd4, 16'd0,    26'h0000100, 32'd0, 32'd0);
        drive("R8 register jump",       1, 3'd5, 16'd0,    26'd0, 32'h0FFF_FFFC, 32'd1);
        drive("R6 jump region from pc4",1, 3'd3, 16'd0,    26'h3FF_FFFF, 32'd0, 32'd0);
        drive("R2 unused code 6",       1, 3'd6, 16'h1234, 26'd5, 32'd3, 32'd3);
        drive("R2 unused code 7",       1, 3'd7, 16'h1234, 26'd5, 32'd3, 32'd3);
        drive("R5 beq max negative",    1, 3'd1, 16'h8000, 26'd0, 32'd4, 32'd4);
        drive("R5 bne max positive",    1, 3'd2, 16'h7FFF, 26'd0, 32'd4, 32'd5);
        drive("R8 unaligned jump",      1, 3'd5, 16'd0,    26'd0, 32'hDEAD_BEEF, 32'd0);
        drive("R7 jal at region end",   1, 3'd5, 16'd0,    26'd0, 32'h7FFF_FFFC, 32'd0);
        drive("R7 jal crosses nibble",  1, 3'd4, 16'd0,    26'h000_0040, 32'd0, 32'd0);

        // R1: reset is synchronous; PC must not move before the edge.
        @(negedge clk);
        rst_n = 1'b0; step_en = 1'b1; flow_kind = 3'd3;
        #3;
        check(pc_q === model_pc, "R1 no reset between edges", pc_q, model_pc);
        @(posedge clk);
        #2;
        check(pc_q === RV, "R1 reset mid-run", pc_q, RV);
        model_pc = RV;
        @(negedge clk);
        rst_n = 1'b1;

        seed = 32'h1357_9BDF;
        for (int i = 0; i < 60; i++) begin
            logic [2:0] fk;
            seed = seed * 32'd1664525 + 32'd1013904223;
            fk = seed[30:28];
            drive("R2 R3 R4 R6 R8 mixed", seed[27] | seed[26], fk, seed[15:0], seed[25:0],
                  {28'd0, seed[19:16]}, {28'd0, seed[23:20]});
        end
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule